// File: doc/BRIEF.md
# Camera Frame Capture with Column/Row Readout

This block sits between a parallel-output camera sensor and a slow host processor. While capturing, it watches the sensor's vertical sync, horizontal sync, pixel clock and 8-bit byte bus. It writes every byte that arrives while both sync lines are high into an external single-port frame RAM. The bytes go to consecutive addresses, starting at zero. When vertical sync drops after at least one stored byte, the frame is complete. The block then clears its write address and raises a done flag.

While the done flag is high, the block is in readout mode. The host places a column, a row and a byte index on its inputs. The block turns them into a RAM address using the configured image width and bytes per pixel, and drives the addressed byte onto the host data bus. Outside readout mode, that bus is released to high impedance. A capture request from the host clears the done flag and arms the next frame.

The sensor lines are asynchronous to the system clock. They pass through a small synchronizer and are edge-detected in the system clock domain, so the system clock must run at least four times as fast as the pixel clock.

Top module: `dvp_xy_frame_bridge`

## Requirements
- R1: A byte is stored only if both vertical and horizontal sync are high when the pixel clock rises. Bytes seen with either sync low cause no RAM write.
- R2: Each stored byte produces exactly one write strobe, and the RAM write data equals the sensor byte.
- R3: The first byte of a frame goes to address 0. Each following stored byte goes to the previous address plus one, and the address advances on the falling pixel clock edge after the write.
- R4: A falling edge of vertical sync, after at least one byte of the frame has been stored, sets frame_done high and returns the write address to 0.
- R5: In readout mode, mem_addr equals bpp*col + bpp*(4*cfg_width_q)*row + rd_byte, taken modulo 2^19. Here bpp is cfg_bpp, and cfg_width_q holds the image width divided by four.
- R6: host_data is high impedance while frame_done is low. While frame_done is high, host_data[7:0] carries mem_rdata and host_data[9:8] are zero.
- R7: While frame_done is high, sensor activity causes no RAM write and leaves frame_done high.
- R8: A cap_req pulse in readout mode clears frame_done, and the next captured frame starts again at address 0.
- R9: After reset, the block is in capture mode with frame_done low and no write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cam_vsync | input | 1 | Sensor vertical sync, high during frame |
| cam_hsync | input | 1 | Sensor horizontal sync, high during valid row bytes |
| cam_pclk | input | 1 | Sensor pixel clock |
| cam_data | input | 8 | Sensor byte bus |
| cfg_width_q | input | 8 | Image width divided by four |
| cfg_bpp | input | 3 | Bytes per pixel |
| cap_req | input | 1 | Arm capture of the next frame |
| rd_col | input | 10 | Readout column |
| rd_row | input | 9 | Readout row |
| rd_byte | input | 2 | Byte offset inside the pixel |
| mem_addr | output | 19 | Frame RAM address (write or read) |
| mem_we | output | 1 | Frame RAM write strobe |
| mem_wdata | output | 8 | Frame RAM write data |
| mem_rdata | input | 8 | Frame RAM read data |
| host_data | output | 10 | Host byte bus, high impedance during capture |
| frame_done | output | 1 | Frame stored, readout mode |

## Verification
The bench keeps the default 19-bit address and 2-stage synchronizer. It runs the sensor clock at one eighth of the system clock, which keeps the edge detector inside its supported rate.

Two frames are captured with different shapes: an 8-pixel-wide, 2-byte-per-pixel image, then a 4-pixel-wide, 1-byte image. Between them, the bench re-arms capture, which shows the write address restarting at zero.

A configuration at the field maxima (width field 255, four bytes per pixel, column 1023, row 511) drives the read-address product past 2^19. This exercises the wrap of the address.

// File: rtl/cfb_pkg.sv
`timescale 1ns/1ps
package cfb_pkg;
  localparam int PIX_W = 8;

  typedef struct packed {
    logic             vs;
    logic             hs;
    logic             pclk;
    logic [PIX_W-1:0] data;
  } cam_smp_t;

  localparam int SMP_W = $bits(cam_smp_t);
endpackage

// File: rtl/cfb_sync.sv
`timescale 1ns/1ps
module cfb_sync #(
  parameter int WIDTH  = 11,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= async_in;
      for (int i = 1; i < STAGES; i++) begin
        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/cfb_wr_ctrl.sv
`timescale 1ns/1ps
module cfb_wr_ctrl
  import cfb_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cam_smp_t          smp,
  input  logic              cap_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              we,
  output logic [PIX_W-1:0]  wdata,
  output logic              frame_done
);
  logic pclk_q, vs_q;
  logic pend_q, seen_q;

  // named events for the assertions
  logic pclk_rise, pclk_fall, vs_fall, sync_valid;
  assign pclk_rise  = smp.pclk & ~pclk_q;
  assign pclk_fall  = ~smp.pclk & pclk_q;
  assign vs_fall    = ~smp.vs & vs_q;
  assign sync_valid = smp.vs & smp.hs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pclk_q     <= 1'b0;
      vs_q       <= 1'b0;
      pend_q     <= 1'b0;
      seen_q     <= 1'b0;
      wr_addr    <= '0;
      we         <= 1'b0;
      wdata      <= '0;
      frame_done <= 1'b0;
    end else begin
      pclk_q <= smp.pclk;
      vs_q   <= smp.vs;
      we     <= 1'b0;
      if (!frame_done) begin
        if (pclk_rise && sync_valid) begin
          we     <= 1'b1;
          wdata  <= smp.data;
          pend_q <= 1'b1;
          seen_q <= 1'b1;
        end
        if (pclk_fall && pend_q) begin
          wr_addr <= wr_addr + 1'b1;
          pend_q  <= 1'b0;
        end
        if (vs_fall && seen_q) begin
          wr_addr    <= '0;
          pend_q     <= 1'b0;
          seen_q     <= 1'b0;
          frame_done <= 1'b1;
        end
      end else if (cap_req) begin
        frame_done <= 1'b0;
      end
    end
  end

  a_r1_write_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> $past(sync_valid));
  a_r3_addr_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_addr != $past(wr_addr)) |-> (wr_addr == $past(wr_addr) + 1'b1 || wr_addr == '0));
  a_r4_clear_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_done) |-> (wr_addr == '0));
  a_r7_no_write_in_readout: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !we);
  a_r8_rearm_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_done) |-> (wr_addr == '0));
endmodule

// File: rtl/cfb_rd_addr.sv
`timescale 1ns/1ps
module cfb_rd_addr #(
  parameter int ADDR_W = 19,
  parameter int COL_W  = 10,
  parameter int ROW_W  = 9,
  parameter int BIDX_W = 2,
  parameter int WQ_W   = 8,
  parameter int BPP_W  = 3
) (
  input  logic [COL_W-1:0]  col,
  input  logic [ROW_W-1:0]  row,
  input  logic [BIDX_W-1:0] bidx,
  input  logic [WQ_W-1:0]   width_q,
  input  logic [BPP_W-1:0]  bpp,
  output logic [ADDR_W-1:0] rd_addr
);
  localparam int ACC_W = BPP_W + WQ_W + 2 + ROW_W + COL_W + 2;

  function automatic logic [ADDR_W-1:0] xy_to_addr(
    input logic [COL_W-1:0]  c,
    input logic [ROW_W-1:0]  r,
    input logic [BIDX_W-1:0] b,
    input logic [WQ_W-1:0]   wq,
    input logic [BPP_W-1:0]  bp
  );
    logic [ACC_W-1:0] w_full, bytes_per_row, acc;
    w_full        = ACC_W'({wq, 2'b00});
    bytes_per_row = ACC_W'(bp) * w_full;
    acc           = ACC_W'(bp) * ACC_W'(c) + bytes_per_row * ACC_W'(r) + ACC_W'(b);
    return acc[ADDR_W-1:0];
  endfunction

  assign rd_addr = xy_to_addr(col, row, bidx, width_q, bpp);
endmodule

// File: rtl/dvp_xy_frame_bridge.sv
`timescale 1ns/1ps
module dvp_xy_frame_bridge
  import cfb_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int COL_W       = 10,
  parameter int ROW_W       = 9,
  parameter int BIDX_W      = 2,
  parameter int WQ_W        = 8,
  parameter int BPP_W       = 3,
  parameter int HOST_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cam_vsync,
  input  logic              cam_hsync,
  input  logic              cam_pclk,
  input  logic [PIX_W-1:0]  cam_data,
  input  logic [WQ_W-1:0]   cfg_width_q,
  input  logic [BPP_W-1:0]  cfg_bpp,
  input  logic              cap_req,
  input  logic [COL_W-1:0]  rd_col,
  input  logic [ROW_W-1:0]  rd_row,
  input  logic [BIDX_W-1:0] rd_byte,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [PIX_W-1:0]  mem_wdata,
  input  logic [PIX_W-1:0]  mem_rdata,
  output logic [HOST_W-1:0] host_data,
  output logic              frame_done
);
  cam_smp_t          raw_smp, smp;
  logic [ADDR_W-1:0] wr_addr, rd_addr;

  assign raw_smp = '{vs: cam_vsync, hs: cam_hsync, pclk: cam_pclk, data: cam_data};

  cfb_sync #(.WIDTH(SMP_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (raw_smp),
    .sync_out (smp)
  );

  cfb_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp        (smp),
    .cap_req    (cap_req),
    .wr_addr    (wr_addr),
    .we         (mem_we),
    .wdata      (mem_wdata),
    .frame_done (frame_done)
  );

  cfb_rd_addr #(
    .ADDR_W(ADDR_W), .COL_W(COL_W), .ROW_W(ROW_W),
    .BIDX_W(BIDX_W), .WQ_W(WQ_W), .BPP_W(BPP_W)
  ) u_rd (
    .col     (rd_col),
    .row     (rd_row),
    .bidx    (rd_byte),
    .width_q (cfg_width_q),
    .bpp     (cfg_bpp),
    .rd_addr (rd_addr)
  );

  assign mem_addr  = frame_done ? rd_addr : wr_addr;
  assign host_data = frame_done ? HOST_W'(mem_rdata) : 'z;

  a_r6_upper_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (host_data[HOST_W-1:PIX_W] == '0));
endmodule

// File: tb/dvp_xy_frame_bridge_tb.sv
`timescale 1ns/1ps
module dvp_xy_frame_bridge_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       vs = 0, hs = 0, pclk = 0;
  logic [7:0] dat = 0;
  logic [7:0] wq = 8'd2;
  logic [2:0] bpp = 3'd2;
  logic       cap_req = 0;
  logic [9:0] col = 0;
  logic [8:0] row = 0;
  logic [1:0] bidx = 0;
  logic [18:0] mem_addr;
  logic        mem_we;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic [9:0]  host_data;
  logic        frame_done;

  logic [7:0] ram [0:1023];
  logic [7:0] img [0:1023];
  assign mem_rdata = ram[mem_addr[9:0]];

  int checks = 0, errors = 0;
  typedef struct {int addr; int data;} wr_t;
  wr_t exp_q[$];

  dvp_xy_frame_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .cam_vsync(vs), .cam_hsync(hs), .cam_pclk(pclk),
    .cam_data(dat), .cfg_width_q(wq), .cfg_bpp(bpp), .cap_req(cap_req),
    .rd_col(col), .rd_row(row), .rd_byte(bidx), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .host_data(host_data), .frame_done(frame_done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: RAM model plus scoreboard compare (R2, R3, R7)
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      wr_t e;
      ram[mem_addr[9:0]] <= mem_wdata;
      if (exp_q.size() == 0) begin
        chk(0, "R7 unexpected write", int'(mem_addr), -1);
      end else begin
        e = exp_q.pop_front();
        chk(int'(mem_addr) == e.addr, "R3 write address", int'(mem_addr), e.addr);
        chk(int'(mem_wdata) == e.data, "R2 write data", int'(mem_wdata), e.data);
      end
    end
  end

  task automatic cam_byte(input logic v, input logic h, input logic [7:0] d);
    pclk = 0; vs = v; hs = h; dat = d;
    #32; pclk = 1; #32;
  endtask

  // driver: sends one frame and pushes expected writes
  task automatic send_frame(input int w_bytes, input int rows, input int seed);
    int a = 0;
    repeat (2) cam_byte(0, 1, 8'hEE);   // R1: hsync alone is blank
    repeat (3) cam_byte(1, 0, 8'hA5);   // R1: vsync alone is blank
    for (int r = 0; r < rows; r++) begin
      for (int i = 0; i < w_bytes; i++) begin
        logic [7:0] d;
        d = 8'((seed + a * 13) & 255);
        img[a] = d;
        exp_q.push_back('{a, int'(d)});
        cam_byte(1, 1, d);
        a++;
      end
      repeat (2) cam_byte(1, 0, 8'h5A);
    end
    repeat (3) cam_byte(0, 0, 8'h00);
    pclk = 0;
  endtask

  task automatic rd_chk(input int c, input int r, input int b);
    int ea;
    col = 10'(c); row = 9'(r); bidx = 2'(b);
    repeat (2) @(posedge clk);
    @(negedge clk);
    ea = (int'(bpp) * c + int'(bpp) * 4 * int'(wq) * r + b) % 524288;
    chk(int'(mem_addr) == ea, "R5 read address", int'(mem_addr), ea);
    chk(host_data === {2'b00, img[ea]}, "R6 host data", int'(host_data), int'(img[ea]));
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1000000;
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(frame_done == 0, "R9 frame_done after reset", int'(frame_done), 0);
    chk(mem_we == 0, "R9 no write after reset", int'(mem_we), 0);
    chk(host_data === 10'bz, "R6 high-Z in capture", int'(host_data), 0);
    rst_n = 1;
    repeat (3) @(posedge clk);

    // frame 1: W = 8, 2 bytes per pixel, 3 rows
    send_frame(16, 3, 7);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, "R1 blank bytes not stored", exp_q.size(), 0);
    chk(frame_done == 1, "R4 frame_done after vsync fall", int'(frame_done), 1);
    chk(host_data[9:8] == 2'b00, "R6 upper host bits", int'(host_data[9:8]), 0);
    rd_chk(0, 0, 0);
    rd_chk(0, 0, 1);
    rd_chk(7, 0, 1);
    rd_chk(3, 1, 0);
    rd_chk(7, 2, 1);
    rd_chk(5, 2, 0);

    // R7: sensor traffic during readout
    repeat (6) cam_byte(1, 1, 8'hFF);
    cam_byte(0, 0, 8'h00);
    pclk = 0;
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(frame_done == 1, "R7 stays in readout", int'(frame_done), 1);
    rd_chk(3, 1, 0);

    // R5 wrap at field maxima
    wq = 8'd255; bpp = 3'd4; col = 10'd1023; row = 9'd511; bidx = 2'd3;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(int'(mem_addr) == 516111, "R5 address wrap", int'(mem_addr), 516111);

    // R8: re-arm, frame 2: W = 4, 1 byte per pixel, 2 rows
    wq = 8'd1; bpp = 3'd1;
    @(negedge clk); cap_req = 1;
    @(negedge clk); cap_req = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(frame_done == 0, "R8 cap_req clears done", int'(frame_done), 0);
    chk(host_data === 10'bz, "R6 high-Z after re-arm", int'(host_data), 0);
    send_frame(4, 2, 99);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, "R8 second frame writes complete", exp_q.size(), 0);
    chk(frame_done == 1, "R4 second frame done", int'(frame_done), 1);
    rd_chk(3, 1, 0);
    rd_chk(0, 1, 0);
    rd_chk(2, 0, 0);
    finish_run();
  end
endmodule